// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block is the address engine of one DMA channel. Software programs a line pitch, a control word, a line length and a line count, then writes a start word address. That last write starts the engine. The engine then presents one 32-bit word address per beat on a valid/ready request port. The request address register also serves as the progress readback, so software can work out how many bytes remain.

With a non-zero line length the engine walks a strided rectangle. Each line is a run of consecutive words, and the next line begins one pitch further on. After the last word of the last line it pulses a completion event and returns to idle.

With a zero line length the same registers describe a loop area of pitch × (count + 1) words. The engine walks this area in a circle until it is stopped. It pulses one event at the end of the first half of the area and another at the end of the second half, on every pass. Data movement, bus protocol and peripheral handshakes belong to other blocks.

The sequencer has three states:
- IDLE: nothing requested.
- LINES: strided run.
- LOOP: circular run.

Its transitions are:
- IDLE→LINES: start written with a non-zero length.
- IDLE→LOOP: start written with a zero length.
- LINES→IDLE: last beat accepted, or stop.
- LOOP→IDLE: stop.

Top module: `dma2d_addr_gen`

## Requirements
- R1: During and after reset, req_valid, evt_done, evt_half and evt_wrap are low and req_addr, req_chan, req_burst4 and req_dir are zero.
- R2: cfg_sel codes are 0 pitch, 1 control, 2 line length, 3 line count (lines minus one) and 4 start word address. A write to code 4 while idle puts req_valid high in the next cycle, with req_addr equal to the written value.
- R3: Control word bits [3:0] are the channel, bit 4 is burst-of-4 and bit 5 is direction (1 memory to device, 0 device to memory). They appear on req_chan, req_burst4 and req_dir from the first beat and are captured at start.
- R4: req_addr advances only on a cycle where req_valid and req_ready are both high. While req_ready is low the address and req_valid hold.
- R5: With line length L > 0 and count C, beat n (counting from 0) addresses start + (n / L) × pitch + (n mod L), for L × (C + 1) beats. Addresses wrap modulo 2^32.
- R6: The cycle after the last beat is accepted, evt_done is high for exactly one cycle and req_valid is low. req_addr keeps the last word address.
- R7: With L = 0, beat n addresses start + (n mod A), where A = pitch × (C + 1). The run continues until stopped.
- R8: In loop mode, evt_wrap pulses the cycle after the beat at offset A − 1 is accepted. evt_half pulses the cycle after the beat at offset floor(A/2) − 1, or never if floor(A/2) is 0. Both repeat on every pass.
- R9: stop high makes req_valid low in the next cycle. A beat accepted in the stop cycle raises no event and does not move req_addr. Stop takes priority over a start write in the same cycle.
- R10: A start write while running is ignored. Writes to the other registers while running do not alter the current run, but they apply to the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| stop | input | 1 | Abort to idle |
| req_ready | input | 1 | Memory side accepts the current beat |
| req_valid | output | 1 | A word request is presented |
| req_addr | output | 32 | Current word address (also progress readback) |
| req_chan | output | 4 | Channel number of the run |
| req_burst4 | output | 1 | Burst-of-4 mode of the run |
| req_dir | output | 1 | Direction of the run |
| evt_done | output | 1 | Strided run completed |
| evt_half | output | 1 | Loop reached end of first half |
| evt_wrap | output | 1 | Loop reached end of area |

## Verification
The bench targets line turns where the pitch exceeds the line length. A design that simply increments the address there would run into the gap.

It targets single-word transfers, where a design that tests the line end too late would issue an extra beat. It also targets an odd loop area and a one-word loop area, where a half-point off by one would fire the half event early, late or on every beat. Finally, it targets stop and start writes that collide with a running transfer or an accepted beat. A design that let them through would restart mid-run, emit a stray event or keep requesting after the abort.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINES = 2'd1,
        ST_LOOP  = 2'd2
    } eng_state_e;

    // Field order matches the control word: bit 5 dir, bit 4 burst, [3:0] channel.
    typedef struct packed {
        logic       dir;
        logic       burst4;
        logic [3:0] chan;
    } xfer_ctl_t;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_PITCH = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTL   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_LEN   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_START = 3'd4;

endpackage

// File: rtl/dma2d_cfg.sv
module dma2d_cfg
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    wdata,
    output logic [LW-1:0]    pitch,
    output logic [LW-1:0]    len,
    output logic [LW-1:0]    count,
    output xfer_ctl_t        ctl,
    output logic             start_req,
    output logic [AW-1:0]    start_addr
);

    localparam int CTL_W = $bits(xfer_ctl_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pitch <= '0;
            len   <= '0;
            count <= '0;
            ctl   <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_PITCH: pitch <= wdata[LW-1:0];
                SEL_LEN:   len   <= wdata[LW-1:0];
                SEL_COUNT: count <= wdata[LW-1:0];
                SEL_CTL:   ctl   <= xfer_ctl_t'(wdata[CTL_W-1:0]);
                default:   ;
            endcase
        end
    end

    // The start register is not stored: its write is the trigger.
    assign start_req  = we && (sel == SEL_START);
    assign start_addr = wdata;

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] len,
    input  logic [LW-1:0] count,
    input  logic [LW-1:0] pitch,
    input  xfer_ctl_t     ctl_in,
    input  logic          step,
    output logic [AW-1:0] addr,
    output xfer_ctl_t     ctl_q,
    output logic          last_beat,
    output logic          at_half,
    output logic          at_end
);

    localparam int AREA_W = 2 * LW + 1;

    logic [AW-1:0]     addr_q, base_q;
    logic [LW-1:0]     x_q, y_q, len_q, count_q, pitch_q;
    logic [AREA_W-1:0] off_q, area_q, half_q, area_d;
    logic              loop_q;

    assign area_d = AREA_W'(pitch) * (AREA_W'(count) + AREA_W'(1));

    assign last_beat = !loop_q && (x_q == len_q - LW'(1)) && (y_q == count_q);
    assign at_end    = loop_q && ((off_q + AREA_W'(1)) >= area_q);
    assign at_half   = loop_q && (half_q != '0) && (off_q == half_q - AREA_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            base_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            off_q   <= '0;
            len_q   <= '0;
            count_q <= '0;
            pitch_q <= '0;
            area_q  <= '0;
            half_q  <= '0;
            loop_q  <= 1'b0;
            ctl_q   <= '0;
        end else if (load) begin
            addr_q  <= start_addr;
            base_q  <= start_addr;
            x_q     <= '0;
            y_q     <= '0;
            off_q   <= '0;
            len_q   <= len;
            count_q <= count;
            pitch_q <= pitch;
            area_q  <= area_d;
            half_q  <= area_d >> 1;
            loop_q  <= (len == '0);
            ctl_q   <= ctl_in;
        end else if (step) begin
            if (loop_q) begin
                if (at_end) begin
                    addr_q <= base_q;
                    off_q  <= '0;
                end else begin
                    addr_q <= addr_q + AW'(1);
                    off_q  <= off_q + AREA_W'(1);
                end
            end else if (x_q == len_q - LW'(1)) begin
                if (y_q != count_q) begin
                    base_q <= base_q + AW'(pitch_q);
                    addr_q <= base_q + AW'(pitch_q);
                    x_q    <= '0;
                    y_q    <= y_q + LW'(1);
                end
            end else begin
                x_q    <= x_q + LW'(1);
                addr_q <= addr_q + AW'(1);
            end
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
    import dma2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       loop_sel,
    input  logic       stop,
    input  logic       beat,
    input  logic       last_beat,
    input  logic       at_half,
    input  logic       at_end,
    output eng_state_e state,
    output logic       load,
    output logic       evt_done,
    output logic       evt_half,
    output logic       evt_wrap
);

    eng_state_e state_d;

    assign load = (state == ST_IDLE) && start_req && !stop;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (load) state_d = loop_sel ? ST_LOOP : ST_LINES;
            end
            ST_LINES: begin
                if (stop || (beat && last_beat)) state_d = ST_IDLE;
            end
            ST_LOOP: begin
                if (stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_done <= 1'b0;
            evt_half <= 1'b0;
            evt_wrap <= 1'b0;
        end else begin
            evt_done <= (state == ST_LINES) && beat && last_beat && !stop;
            evt_half <= (state == ST_LOOP)  && beat && at_half   && !stop;
            evt_wrap <= (state == ST_LOOP)  && beat && at_end    && !stop;
        end
    end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             stop,
    input  logic             req_ready,
    output logic             req_valid,
    output logic [AW-1:0]    req_addr,
    output logic [3:0]       req_chan,
    output logic             req_burst4,
    output logic             req_dir,
    output logic             evt_done,
    output logic             evt_half,
    output logic             evt_wrap
);

    logic [LW-1:0] pitch, len, count;
    xfer_ctl_t     ctl, ctl_q;
    logic          start_req, load, beat, last_beat, at_half, at_end;
    logic [AW-1:0] start_addr;
    eng_state_e    state;

    dma2d_cfg #(.AW(AW), .LW(LW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .pitch      (pitch),
        .len        (len),
        .count      (count),
        .ctl        (ctl),
        .start_req  (start_req),
        .start_addr (start_addr)
    );

    dma2d_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .loop_sel  (len == '0),
        .stop      (stop),
        .beat      (beat),
        .last_beat (last_beat),
        .at_half   (at_half),
        .at_end    (at_end),
        .state     (state),
        .load      (load),
        .evt_done  (evt_done),
        .evt_half  (evt_half),
        .evt_wrap  (evt_wrap)
    );

    dma2d_walk #(.AW(AW), .LW(LW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .len        (len),
        .count      (count),
        .pitch      (pitch),
        .ctl_in     (ctl),
        .step       (beat && !stop),
        .addr       (req_addr),
        .ctl_q      (ctl_q),
        .last_beat  (last_beat),
        .at_half    (at_half),
        .at_end     (at_end)
    );

    assign req_valid  = (state != ST_IDLE);
    assign beat       = req_valid && req_ready;
    assign req_chan   = ctl_q.chan;
    assign req_burst4 = ctl_q.burst4;
    assign req_dir    = ctl_q.dir;

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic [AW-1:0] cfg_wdata,
    input logic          stop,
    input logic          req_ready,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          evt_done,
    input logic          evt_half,
    input logic          evt_wrap
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && cfg_we && cfg_sel == 3'd4 && !stop) |=> (req_valid && req_addr == $past(cfg_wdata))); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !stop) |=> (req_valid && $stable(req_addr))); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> !req_valid); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done); // R6

    AST_LOOP_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_half || evt_wrap) |-> req_valid); // R7

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_done, evt_half, evt_wrap})); // R8

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!req_valid && !evt_done && !evt_half && !evt_wrap)); // R9

endmodule

bind dma2d_addr_gen dma2d_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        stop = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid, req_burst4, req_dir, evt_done, evt_half, evt_wrap;
    logic [31:0] req_addr;
    logic [3:0]  req_chan;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dma2d_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stop(stop), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_chan(req_chan),
        .req_burst4(req_burst4), .req_dir(req_dir), .evt_done(evt_done),
        .evt_half(evt_half), .evt_wrap(evt_wrap)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lin_addr(input logic [31:0] st, input int len,
                                             input int pitch, input int idx);
        return st + 32'((idx / len) * pitch) + 32'(idx % len);
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] st, input int len, input int cnt,
                         input int pitch, input logic [5:0] ctl);
        wr(3'd0, 32'(pitch));
        wr(3'd1, 32'(ctl));
        wr(3'd2, 32'(len));
        wr(3'd3, 32'(cnt));
        wr(3'd4, st);
    endtask

    // Strided run; poke_len >= 0 injects start and length writes mid-run (R10).
    task automatic run_lines(input logic [31:0] st, input int len, input int cnt,
                             input int pitch, input logic [5:0] ctl, input int rdy_pct,
                             input bit do_cfg, input int poke_len, input int stop_at);
        int total = len * (cnt + 1);
        int idx = 0;
        int cyc = 0;
        string tag = (poke_len >= 0) ? "R10" : "R5";
        if (do_cfg) setup(st, len, cnt, pitch, ctl);
        else wr(3'd4, st);
        while (idx < total && cyc < 4000) begin
            check(req_valid === 1'b1, "R2", "valid while running", req_valid, 1);
            check(req_addr == lin_addr(st, len, pitch, idx), tag, "beat address",
                  req_addr, lin_addr(st, len, pitch, idx));
            check(evt_done === 1'b0, "R6", "no early done", evt_done, 0);
            if (cyc == 0)
                check({req_dir, req_burst4, req_chan} == ctl, "R3", "control fields",
                      {req_dir, req_burst4, req_chan}, ctl);
            if (stop_at >= 0 && cyc == stop_at) begin
                stop = 1'b1; req_ready = 1'(($urandom % 2));
                @(negedge clk);
                stop = 1'b0; req_ready = 1'b0;
                check(req_valid === 1'b0, "R9", "stop idles", req_valid, 0);
                check(evt_done === 1'b0, "R9", "no event on stop", evt_done, 0);
                check(req_addr == lin_addr(st, len, pitch, idx), "R9", "address frozen",
                      req_addr, lin_addr(st, len, pitch, idx));
                return;
            end
            if (poke_len >= 0) begin
                if (cyc == 2) begin cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'hDEAD_0000; end
                else if (cyc == 3) begin cfg_sel = 3'd2; cfg_wdata = 32'(poke_len); end
                else if (cyc == 4) cfg_we = 1'b0;
            end
            req_ready = 1'(($urandom % 100) < rdy_pct);
            begin
                bit acc = req_ready;
                @(negedge clk);
                if (acc) idx++;
            end
            cyc++;
        end
        cfg_we = 1'b0;
        req_ready = 1'b0;
        check(req_valid === 1'b0, "R6", "idle after last beat", req_valid, 0);
        check(evt_done === 1'b1, "R6", "done pulse", evt_done, 1);
        check(req_addr == lin_addr(st, len, pitch, total - 1), "R6", "address holds last",
              req_addr, lin_addr(st, len, pitch, total - 1));
        @(negedge clk);
        check(evt_done === 1'b0, "R6", "done is one cycle", evt_done, 0);
    endtask

    task automatic run_loop(input logic [31:0] st, input int cnt, input int pitch,
                            input int beats, input int rdy_pct);
        int area = pitch * (cnt + 1);
        int half = area / 2;
        int idx = 0;
        int cyc = 0;
        bit ph = 0;
        bit pw = 0;
        setup(st, 0, cnt, pitch, 6'h00);
        while (idx < beats && cyc < 4000) begin
            int off = idx % area;
            check(req_valid === 1'b1, "R7", "loop keeps running", req_valid, 1);
            check(req_addr == st + 32'(off), "R7", "loop address", req_addr, st + 32'(off));
            check(evt_half === ph, "R8", "half event", evt_half, ph);
            check(evt_wrap === pw, "R8", "wrap event", evt_wrap, pw);
            req_ready = 1'(($urandom % 100) < rdy_pct);
            ph = req_ready && half > 0 && off == half - 1;
            pw = req_ready && off == area - 1;
            begin
                bit acc = req_ready;
                @(negedge clk);
                if (acc) idx++;
            end
            cyc++;
        end
        check(evt_half === ph, "R8", "final half event", evt_half, ph);
        check(evt_wrap === pw, "R8", "final wrap event", evt_wrap, pw);
        stop = 1'b1; req_ready = 1'b1;
        @(negedge clk);
        stop = 1'b0; req_ready = 1'b0;
        check(req_valid === 1'b0, "R9", "stop ends loop", req_valid, 0);
        check(!evt_half && !evt_wrap, "R9", "no event on stop beat", {evt_half, evt_wrap}, 0);
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(req_valid === 1'b0 && evt_done === 1'b0 && evt_half === 1'b0 && evt_wrap === 1'b0,
              "R1", "outputs in reset", {req_valid, evt_done, evt_half, evt_wrap}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_addr == 32'd0 && {req_dir, req_burst4, req_chan} == 6'd0 && !req_valid,
              "R1", "state after reset", req_addr, 0);

        // R5 basic stride with gap, full-rate and stalled
        run_lines(32'h0000_0100, 3, 2, 8, 6'h25, 100, 1, -1, -1);
        run_lines(32'h0000_4000, 4, 3, 6, 6'h1A, 40, 1, -1, -1);
        // single word, contiguous lines, address wrap at 2^32
        run_lines(32'h0000_0777, 1, 0, 0, 6'h03, 100, 1, -1, -1);
        run_lines(32'h0001_0000, 5, 2, 5, 6'h30, 70, 1, -1, -1);
        run_lines(32'hFFFF_FFFE, 2, 1, 4, 6'h0F, 60, 1, -1, -1);
        // R10 writes while running, then a start-only run picks up the new length
        run_lines(32'h0000_2000, 3, 3, 4, 6'h11, 50, 1, 2, -1);
        run_lines(32'h0000_3000, 2, 3, 4, 6'h11, 80, 0, -1, -1);
        // R9 stop mid strided run, then stop colliding with a start write
        run_lines(32'h0000_5000, 4, 4, 8, 6'h22, 60, 1, -1, 5);
        stop = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0000_9000;
        @(negedge clk);
        stop = 1'b0; cfg_we = 1'b0;
        check(req_valid === 1'b0, "R9", "stop beats start", req_valid, 0);
        // R7 R8 loop areas: even, odd, single word
        run_loop(32'h0000_8000, 1, 4, 20, 70);
        run_loop(32'h0000_8100, 0, 5, 12, 100);
        run_loop(32'h0000_8200, 0, 1, 4, 60);
        run_loop(32'h0000_8300, 2, 2, 15, 50);
        // random strided runs
        for (int i = 0; i < 8; i++) begin
            int len = 1 + int'($urandom % 5);
            int cnt = int'($urandom % 4);
            int pitch = len + int'($urandom % 5);
            run_lines($urandom, len, cnt, pitch, 6'($urandom), 30 + int'($urandom % 70), 1, -1, -1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule